// File: doc/BRIEF.md
# Pin Interrupt Sense Controller

This block watches a vector of already-synchronized input pins and turns selected transitions or levels on them into interrupts. For every pin, software picks a detection condition from a 4-bit code: rising edge, falling edge, both edges, high level or low level. A per-pin detection-enable bit decides whether matching events are captured at all. A separate interrupt mask decides whether a captured event reaches an interrupt line.

Captured events collect in a raw status vector. Software acknowledges an event by writing a one to its bit in a clear register. A masked view of the status feeds two interrupt outputs. One output covers the lower half of the pins and the other covers the upper half.

Software reaches the block through a simple word register port. The port has a write strobe, a byte address, write data and combinational read data. The per-pin codes sit in a second window of registers that starts at byte offset 0x40.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the detection-enable vector, the interrupt mask, the raw status and all sense codes are zero. Every readable register returns 0, and both interrupt outputs are low.
- R2: Sense code 0 (bits 2:0 = 0) captures a pin when it is 1 and was 0 on the previous cycle. The status bit is visible on the clock edge that samples the new value. Bit 3 of the code has no effect on detection.
- R3: Sense code 1 captures a pin when it is 0 and was 1 on the previous cycle.
- R4: Sense code 4 captures both rising and falling transitions.
- R5: Sense code 2 captures on every cycle the pin is 1, and code 3 on every cycle the pin is 0. If the level is still active, a bit cleared by acknowledge sets again on the following edge.
- R6: Sense codes whose bits 2:0 are 5, 6 or 7 never capture an event.
- R7: Offset 0x14 is a read/write detection-enable vector. While bit n is 0, no event of pin n is captured, and status already latched stays unchanged.
- R8: Writing 1 to bit n at offset 0x18 unmasks pin n, and writing 1 to bit n at offset 0x1C masks it. Zero bits leave the mask unchanged, and offset 0x1C reads back the mask.
- R9: Writing 1 to bit n at offset 0x28 clears raw status bit n on that edge. The clear takes priority over an event of the same cycle.
- R10: Offset 0x20 reads the raw status vector, and offset 0x24 reads raw status ANDed with the mask.
- R11: The low interrupt output is high exactly while a masked status bit in the lower half of the pins is set. The high output does the same for the upper half.
- R12: Offsets 0x40 + 4*i hold the 4-bit codes of pins 8i to 8i+7. The code of pin 8i+j sits at bits 4j+3:4j and reads back as written, including bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| pinIn | input | 32 | Synchronized pin levels |
| irqLow | output | 1 | Interrupt for the lower half of the pins |
| irqHigh | output | 1 | Interrupt for the upper half of the pins |

## Verification
Some internal faults stay hidden in the status until something else happens. A stale previous-pin sample or a misdecoded sense code sets the wrong status bit one edge after the pin change. That bit shows on the interrupt outputs at once only if the pin is unmasked. Otherwise it appears only when the raw status is read. A lost acknowledge or a wrong priority between clear and event shows on the very next cycle, as a bit or interrupt line still high. For this reason the bench compares both interrupt lines against a reference model on every cycle, and reads back the registers after each stimulus.

// File: rtl/gpio_irq_sense_pkg.sv
package gpio_irq_sense_pkg;

  // Detection conditions held in bits 2:0 of a pin's sense code
  localparam logic [2:0] SENSE_RISE = 3'd0;
  localparam logic [2:0] SENSE_FALL = 3'd1;
  localparam logic [2:0] SENSE_HIGH = 3'd2;
  localparam logic [2:0] SENSE_LOW  = 3'd3;
  localparam logic [2:0] SENSE_BOTH = 3'd4;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_DETEN,
    RD_MASK,
    RD_RAW,
    RD_MASKED,
    RD_SENSE
  } rdSel_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic       detEnWr;
    logic       unmaskWr;
    logic       maskWr;
    logic       ackWr;
    logic       senseWr;
    logic [3:0] senseIdx;
    rdSel_e     rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_irq_sense_ctrl.sv
module gpio_irq_sense_ctrl
  import gpio_irq_sense_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int SENSE_REGS = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DETEN  = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_UNMASK = WORD_W'(6);
  localparam logic [WORD_W-1:0] W_MASK   = WORD_W'(7);
  localparam logic [WORD_W-1:0] W_RAW    = WORD_W'(8);
  localparam logic [WORD_W-1:0] W_MSKD   = WORD_W'(9);
  localparam logic [WORD_W-1:0] W_ACK    = WORD_W'(10);
  localparam logic [WORD_W-1:0] W_SENSE  = WORD_W'(16);
  localparam logic [WORD_W-1:0] W_SENSE_END = WORD_W'(16 + SENSE_REGS);

  logic [WORD_W-1:0] wordAddr;
  logic [WORD_W-1:0] senseOff;
  logic              aligned;
  logic              inSense;

  assign wordAddr = regAddr[ADDR_W-1:2];
  assign aligned  = (regAddr[1:0] == 2'b00);
  assign senseOff = wordAddr - W_SENSE;
  assign inSense  = (wordAddr >= W_SENSE) && (wordAddr < W_SENSE_END);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_ZERO;
    strobe.senseIdx = 4'(senseOff);
    if (aligned) begin
      if (inSense) begin
        strobe.senseWr = regWrEn;
        strobe.rdSel   = RD_SENSE;
      end else begin
        unique case (wordAddr)
          W_DETEN: begin
            strobe.detEnWr = regWrEn;
            strobe.rdSel   = RD_DETEN;
          end
          W_UNMASK: strobe.unmaskWr = regWrEn;
          W_MASK: begin
            strobe.maskWr = regWrEn;
            strobe.rdSel  = RD_MASK;
          end
          W_RAW:  strobe.rdSel = RD_RAW;
          W_MSKD: strobe.rdSel = RD_MASKED;
          W_ACK:  strobe.ackWr = regWrEn;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_irq_sense_detect.sv
module gpio_irq_sense_detect
  import gpio_irq_sense_pkg::*;
(
  input  logic       pinNow,
  input  logic       pinPrev,
  input  logic [2:0] mode,
  output logic       hit
);

  always_comb begin
    unique case (mode)
      SENSE_RISE: hit = pinNow & ~pinPrev;
      SENSE_FALL: hit = ~pinNow & pinPrev;
      SENSE_HIGH: hit = pinNow;
      SENSE_LOW:  hit = ~pinNow;
      SENSE_BOTH: hit = pinNow ^ pinPrev;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_sense_dp.sv
module gpio_irq_sense_dp
  import gpio_irq_sense_pkg::*;
#(
  parameter int PIN_COUNT      = 32,
  parameter int CODE_W         = 4,
  parameter int FIELDS_PER_REG = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] rawVec,
  output logic [PIN_COUNT-1:0] maskVec,
  output logic [PIN_COUNT-1:0] detEnVec,
  output logic                 irqLow,
  output logic                 irqHigh
);

  localparam int SENSE_REGS = PIN_COUNT / FIELDS_PER_REG;
  localparam int SENSE_W    = FIELDS_PER_REG * CODE_W;
  localparam int HALF       = PIN_COUNT / 2;

  logic [PIN_COUNT-1:0] detEnQ, maskQ, rawQ, prevQ;
  logic [PIN_COUNT-1:0] hitVec, evtVec, ackVec;
  logic [SENSE_W-1:0]   senseQ [SENSE_REGS];

  // Per-pin condition decode
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int RI = p / FIELDS_PER_REG;
    localparam int FI = p % FIELDS_PER_REG;
    gpio_irq_sense_detect u_det (
      .pinNow (pinIn[p]),
      .pinPrev(prevQ[p]),
      .mode   (senseQ[RI][FI*CODE_W +: 3]),
      .hit    (hitVec[p])
    );
  end

  assign evtVec = hitVec & detEnQ;
  assign ackVec = strobe.ackWr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detEnQ <= '0;
      maskQ  <= '0;
      rawQ   <= '0;
      prevQ  <= '0;
    end else begin
      prevQ <= pinIn;
      rawQ  <= (rawQ | evtVec) & ~ackVec;
      if (strobe.detEnWr) detEnQ <= wrData;
      if (strobe.unmaskWr)    maskQ <= maskQ | wrData;
      else if (strobe.maskWr) maskQ <= maskQ & ~wrData;
    end
  end

  for (genvar i = 0; i < SENSE_REGS; i++) begin : g_sense
    always_ff @(posedge clk) begin
      if (!rstN) senseQ[i] <= '0;
      else if (strobe.senseWr && strobe.senseIdx == 4'(i))
        senseQ[i] <= wrData[SENSE_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_DETEN:  rdData = detEnQ;
      RD_MASK:   rdData = maskQ;
      RD_RAW:    rdData = rawQ;
      RD_MASKED: rdData = rawQ & maskQ;
      RD_SENSE: begin
        for (int i = 0; i < SENSE_REGS; i++)
          if (strobe.senseIdx == 4'(i)) rdData = PIN_COUNT'(senseQ[i]);
      end
      default: rdData = '0;
    endcase
  end

  assign irqLow   = |(rawQ[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHigh  = |(rawQ[PIN_COUNT-1:HALF] & maskQ[PIN_COUNT-1:HALF]);
  assign rawVec   = rawQ;
  assign maskVec  = maskQ;
  assign detEnVec = detEnQ;

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_sense_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [PIN_COUNT-1:0] regWrData,
  output logic [PIN_COUNT-1:0] regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic                 irqLow,
  output logic                 irqHigh
);

  localparam int CODE_W         = 4;
  localparam int FIELDS_PER_REG = 8;
  localparam int SENSE_REGS     = PIN_COUNT / FIELDS_PER_REG;

  regStrobe_t           strobe;
  logic [PIN_COUNT-1:0] rawVec, maskVec, detEnVec;

  gpio_irq_sense_ctrl #(
    .ADDR_W    (ADDR_W),
    .SENSE_REGS(SENSE_REGS)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  gpio_irq_sense_dp #(
    .PIN_COUNT     (PIN_COUNT),
    .CODE_W        (CODE_W),
    .FIELDS_PER_REG(FIELDS_PER_REG)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .pinIn   (pinIn),
    .rdData  (regRdData),
    .rawVec  (rawVec),
    .maskVec (maskVec),
    .detEnVec(detEnVec),
    .irqLow  (irqLow),
    .irqHigh (irqHigh)
  );

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [PIN_COUNT-1:0] regWrData,
  input logic [PIN_COUNT-1:0] rawVec,
  input logic [PIN_COUNT-1:0] maskVec,
  input logic [PIN_COUNT-1:0] detEnVec
);

  localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(8'h28);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_ACK) |=> ((rawVec & $past(regWrData)) == '0)); // R9

  AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_UNMASK) |=> ((maskVec & $past(regWrData)) == $past(regWrData))); // R8

  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_MASK) |=> ((maskVec & $past(regWrData)) == '0)); // R8

  AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((rawVec & ~$past(rawVec) & ~$past(detEnVec)) == '0)); // R7

  AST_MASK_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && (regAddr == A_UNMASK || regAddr == A_MASK))) |=> $stable(maskVec)); // R8

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(
  .PIN_COUNT(PIN_COUNT),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .rawVec   (rawVec),
  .maskVec  (maskVec),
  .detEnVec (detEnVec)
);

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] pinIn = '0;
  logic        irqLow, irqHigh;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  gpio_irq_sense u_gpio_irq_sense (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  always #10 clk = ~clk;

  // Reference model state
  logic [31:0] mDet, mMask, mRaw, mPrev, mEv, mAck;
  logic [3:0]  mSense [32];
  logic [2:0]  mCode;
  bit          mHit;

  always @(posedge clk) begin
    if (!rstN) begin
      mDet = 0; mMask = 0; mRaw = 0; mPrev = 0;
      for (int p = 0; p < 32; p++) mSense[p] = 4'h0;
    end else begin
      mEv = 0;
      for (int p = 0; p < 32; p++) begin
        mCode = mSense[p][2:0];
        if (mCode == 3'd0)      mHit = pinIn[p] && !mPrev[p];
        else if (mCode == 3'd1) mHit = !pinIn[p] && mPrev[p];
        else if (mCode == 3'd2) mHit = pinIn[p];
        else if (mCode == 3'd3) mHit = !pinIn[p];
        else if (mCode == 3'd4) mHit = pinIn[p] != mPrev[p];
        else                    mHit = 0;
        if (mHit && mDet[p]) mEv[p] = 1'b1;
      end
      mAck = 0;
      if (regWrEn) begin
        if (regAddr == 7'h14) mDet = regWrData;
        if (regAddr == 7'h18) mMask = mMask | regWrData;
        if (regAddr == 7'h1C) mMask = mMask & ~regWrData;
        if (regAddr == 7'h28) mAck = regWrData;
        if (regAddr >= 7'h40 && regAddr <= 7'h4C && regAddr[1:0] == 2'b00)
          for (int j = 0; j < 8; j++)
            mSense[(regAddr - 7'h40) * 2 + j] = regWrData[4*j +: 4];
      end
      mRaw = (mRaw | mEv) & ~mAck;
      mPrev = pinIn;
    end
  end

  function automatic logic [31:0] mRead(input logic [6:0] a);
    logic [31:0] v;
    v = 0;
    if (a == 7'h14) v = mDet;
    else if (a == 7'h1C) v = mMask;
    else if (a == 7'h20) v = mRaw;
    else if (a == 7'h24) v = mRaw & mMask;
    else if (a >= 7'h40 && a <= 7'h4C && a[1:0] == 2'b00)
      for (int j = 0; j < 8; j++) v[4*j +: 4] = mSense[(a - 7'h40) * 2 + j];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Interrupt lines compared every cycle (R11)
  always @(negedge clk) begin
    if (running) begin
      check("R11 irqLow", {31'b0, irqLow}, {31'b0, |(mRaw[15:0] & mMask[15:0])});
      check("R11 irqHigh", {31'b0, irqHigh}, {31'b0, |(mRaw[31:16] & mMask[31:16])});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [6:0] a, input string tag);
    regAddr = a;
    #1;
    check(tag, regRdData, mRead(a));
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    // R1: reset state
    readReg(7'h14, "R1 detEn");
    readReg(7'h1C, "R1 mask");
    readReg(7'h20, "R1 raw");
    readReg(7'h24, "R1 masked");
    readReg(7'h40, "R1 sense0");
    readReg(7'h4C, "R1 sense3");
    check("R1 raw literal", regRdData, 32'h0);

    // R12: pin0 rise(+async), pin1 fall, pin2 both, pin3 high(+async), pin4 low, pin5 code 5
    writeReg(7'h40, 32'h0053A418);
    readReg(7'h40, "R12 sense0");
    check("R12 literal", regRdData, 32'h0053A418);
    writeReg(7'h48, 32'h0000_0090);
    readReg(7'h48, "R12 sense2");
    writeReg(7'h48, 32'h0);
    writeReg(7'h18, 32'h0003003F);
    readReg(7'h1C, "R8 unmask");
    writeReg(7'h14, 32'hFFFFFFFF);
    readReg(7'h14, "R7 detEn rw");
    tick();
    readReg(7'h20, "R5 low level");

    setPins(32'h1); tick();
    readReg(7'h20, "R2 rise");
    readReg(7'h24, "R10 masked");
    setPins(32'h0002_0001); tick();
    readReg(7'h24, "R11 high half");
    setPins(32'h0002_0000); tick();
    writeReg(7'h28, 32'h1);
    setPins(32'h0002_0000); tick();
    readReg(7'h20, "R2 falling ignored");
    setPins(32'h0002_0002); tick();
    readReg(7'h20, "R3 rise ignored");
    setPins(32'h0002_0000); tick();
    readReg(7'h20, "R3 fall");
    setPins(32'h0002_0004); tick();
    readReg(7'h20, "R4 rise");
    writeReg(7'h28, 32'h4);
    readReg(7'h20, "R9 ack");
    setPins(32'h0002_0000); tick();
    readReg(7'h20, "R4 fall");

    setPins(32'h0002_0008); tick();
    readReg(7'h20, "R5 high");
    writeReg(7'h28, 32'h18);
    readReg(7'h20, "R9 clear wins");
    tick();
    readReg(7'h20, "R5 reassert");

    writeReg(7'h28, 32'hFFFF_FFFF);
    setPins(32'h0002_0028); tick();
    setPins(32'h0002_0008); tick();
    readReg(7'h20, "R6 code5");

    writeReg(7'h1C, 32'h0000_0008);
    readReg(7'h1C, "R8 mask");
    readReg(7'h24, "R10 after mask");

    writeReg(7'h14, 32'hFFFF_FFEB);
    writeReg(7'h28, 32'h0000_0014);
    setPins(32'h0002_000C); tick();
    setPins(32'h0002_0008); tick();
    readReg(7'h20, "R7 disabled");
    readReg(7'h14, "R7 readback");

    for (int it = 0; it < 400; it++) begin
      r = $urandom();
      case (r[14:12])
        3'd0: setPins($urandom());
        3'd1: setPins(pinIn ^ (32'h1 << r[4:0]));
        3'd2: writeReg(7'h28, $urandom());
        3'd3: writeReg(7'h18, $urandom());
        3'd4: writeReg(7'h1C, $urandom() & 32'h0F0F0F0F);
        3'd5: writeReg(7'h14, $urandom() | 32'h00FF00FF);
        3'd6: writeReg(7'h40 | {3'b000, r[6:5], 2'b00}, $urandom());
        default: tick();
      endcase
      case (it % 5)
        0: readReg(7'h20, "R10 raw");
        1: readReg(7'h24, "R10 masked");
        2: readReg(7'h1C, "R8 mask");
        3: readReg(7'h14, "R7 detEn");
        default: readReg(7'h40 | {3'b000, r[9:8], 2'b00}, "R12 sense");
      endcase
    end

    done = 1'b1;
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule